// File: doc/BRIEF.md
# Right-to-Left Modular Exponentiation Controller

This block raises a base to an exponent modulo a modulus, all W bits wide, by scanning the exponent from its least significant bit upward. An accumulator starts at one and a square register starts at the base. Each step runs two modular multipliers side by side. One multiplies the accumulator by either the current square or the constant one, depending on the exponent's low bit. The other squares the square register. Both products are written back on the same clock edge, the exponent moves right by one bit, and the next step begins on that same edge. The run ends once the shifted exponent is zero.

The schedule does not depend on the exponent bits. The accumulator multiplier runs every step and is simply fed one when the bit is clear. The time taken therefore depends only on the bit length of the exponent. Each multiplier is a shift-and-add unit that handles one bit of its second operand per cycle, so a step lasts exactly W cycles.

Operands enter through a valid/ready handshake. A transfer happens on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from that edge until the result has been taken. The result is offered with `out_valid`. It is held unchanged while `out_ready` is low and is released on the edge where both are high. A consumer that never raises `out_ready` stalls the block, and the block then refuses new operands.

Top module: `rl_modexp`

## Requirements
- R1: While reset is active and in the cycle after it is released, `in_ready` is 1 and `out_valid` is 0.
- R2: Operands are captured only on an edge where `in_valid` and `in_ready` are both 1. From that edge until the result is released, `in_ready` is 0, and any change on `in_valid`, `base_i`, `exp_i` or `mod_i` has no effect on the result.
- R3: For a modulus N > 1 and a base x < N, the result equals x^e mod N.
- R4: An exponent of 0 gives a result of 1, and `out_valid` rises on the accepting edge itself.
- R5: For a nonzero exponent of bit length L, `out_valid` rises exactly L·W clock edges after the accepting edge.
- R6: An exponent with its top bit set takes W·W edges (256 at W = 16).
- R7: Two exponents of the same bit length take the same number of cycles whatever their other bits are. Both multipliers finish each step on the same cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `res_o` stays unchanged.
- R9: After an edge where `out_valid` and `out_ready` are both 1, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block idle and able to take operands |
| base_i | input | W | Base x, must be below the modulus |
| exp_i | input | W | Exponent e |
| mod_i | input | W | Modulus N, must be above 1 |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| res_o | output | W | x^e mod N |

## Verification
The result of an operand set is due L·W edges after its accepting edge, where L is the bit length of the exponent. For a zero exponent it is due on the accepting edge itself. Release is due one edge after `out_ready` is seen high.

The driver records the number of the accepting edge before that edge occurs and queues the expected value and latency. The monitor samples on falling edges, so the edge count it reads when `out_valid` first appears can be compared directly against L·W. During the hold window the monitor checks stability once per cycle. It checks release on the falling edge that follows the handshake edge.

// File: rtl/rlx_pkg.sv
package rlx_pkg;
  typedef enum logic [1:0] {
    RLX_IDLE = 2'd0,
    RLX_RUN  = 2'd1,
    RLX_HOLD = 2'd2
  } rlx_state_t;

  localparam int RLX_LANES = 2;   // lane 0: accumulator product, lane 1: squaring
  localparam int RLX_ACC   = 0;
  localparam int RLX_SQ    = 1;
endpackage

// File: rtl/rlx_modmul.sv
// Shift-and-add modular multiplier: one bit of b per cycle, LSB first.
// The load edge already consumes bit 0, so the product is ready W edges
// after load (done pulses in the cycle following the last update).
module rlx_modmul #(
  parameter int W = 224
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] n_i,
  output logic [W-1:0] prod_o,
  output logic         done_o
);
  localparam int CW = $clog2(W) + 1;

  logic [W-1:0]  acc_q, sh_q, bb_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  logic [W:0]   n_x;
  logic [W:0]   a2, a2r, s2, s2r, sm, smr;
  logic [W-1:0] a_dbl, sh_dbl, acc_add;

  always_comb begin
    n_x     = {1'b0, n_i};
    a2      = {a_i, 1'b0};
    a2r     = a2 - n_x;
    a_dbl   = (a2 >= n_x) ? a2r[W-1:0] : a2[W-1:0];
    s2      = {sh_q, 1'b0};
    s2r     = s2 - n_x;
    sh_dbl  = (s2 >= n_x) ? s2r[W-1:0] : s2[W-1:0];
    sm      = {1'b0, acc_q} + {1'b0, sh_q};
    smr     = sm - n_x;
    acc_add = (sm >= n_x) ? smr[W-1:0] : sm[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      sh_q   <= '0;
      bb_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load) begin
        acc_q  <= b_i[0] ? a_i : '0;
        sh_q   <= a_dbl;
        bb_q   <= b_i >> 1;
        cnt_q  <= CW'(1);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (bb_q[0]) acc_q <= acc_add;
        sh_q  <= sh_dbl;
        bb_q  <= bb_q >> 1;
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == CW'(W - 1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign prod_o = acc_q;
endmodule

// File: rtl/rlx_opsel.sv
// Operand selection for both lanes. At acceptance the operands come from
// the input port (A = 1, S = x); at a step boundary from the fresh products.
module rlx_opsel #(
  parameter int W = 224
) (
  input  logic                              from_in,
  input  logic                              bit_in,
  input  logic                              bit_next,
  input  logic [W-1:0]                      x_in,
  input  logic [W-1:0]                      n_in,
  input  logic [W-1:0]                      n_q,
  input  logic [W-1:0]                      prod_acc,
  input  logic [W-1:0]                      prod_sq,
  output logic [rlx_pkg::RLX_LANES-1:0][W-1:0] mul_a,
  output logic [rlx_pkg::RLX_LANES-1:0][W-1:0] mul_b,
  output logic [W-1:0]                      mod_o
);
  import rlx_pkg::*;
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] acc_v, sq_v;
  logic         ebit;

  always_comb begin
    acc_v = from_in ? ONE  : prod_acc;
    sq_v  = from_in ? x_in : prod_sq;
    ebit  = from_in ? bit_in : bit_next;
    mod_o = from_in ? n_in : n_q;
    mul_a[RLX_ACC] = acc_v;
    mul_b[RLX_ACC] = ebit ? sq_v : ONE;   // identity multiply when bit is clear
    mul_a[RLX_SQ]  = sq_v;
    mul_b[RLX_SQ]  = sq_v;
  end
endmodule

// File: rtl/rlx_seq.sv
// Step sequencer: handshakes, accumulator/square/exponent/modulus registers.
module rlx_seq #(
  parameter int W = 224
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] e_in,
  input  logic [W-1:0] n_in,
  input  logic         out_ready,
  input  logic         done_acc,
  input  logic         done_sq,
  input  logic [W-1:0] prod_acc,
  input  logic [W-1:0] prod_sq,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         from_in,
  output logic         bit_next,
  output logic         mul_load,
  output logic [W-1:0] n_q
);
  import rlx_pkg::*;

  rlx_state_t   st_q;
  logic [W-1:0] a_q, s_q, e_q;
  logic [W-1:0] e_shift;
  logic         accept, step_end;

  always_comb begin
    accept   = (st_q == RLX_IDLE) && in_valid;
    step_end = (st_q == RLX_RUN) && done_acc && done_sq;
    e_shift  = e_q >> 1;
    from_in  = accept;
    bit_next = e_shift[0];
    mul_load = (accept && (e_in != '0)) || (step_end && (e_shift != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RLX_IDLE;
      a_q  <= '0;
      s_q  <= '0;
      e_q  <= '0;
      n_q  <= '0;
    end else begin
      unique case (st_q)
        RLX_IDLE: if (accept) begin
          a_q  <= W'(1);
          s_q  <= x_in;
          e_q  <= e_in;
          n_q  <= n_in;
          st_q <= (e_in == '0) ? RLX_HOLD : RLX_RUN;
        end
        RLX_RUN: if (step_end) begin
          a_q <= prod_acc;
          s_q <= prod_sq;
          e_q <= e_shift;
          if (e_shift == '0) st_q <= RLX_HOLD;
        end
        RLX_HOLD: if (out_ready) st_q <= RLX_IDLE;
        default: st_q <= RLX_IDLE;
      endcase
    end
  end

  assign in_ready  = (st_q == RLX_IDLE);
  assign out_valid = (st_q == RLX_HOLD);
  assign result    = a_q;
endmodule

// File: rtl/rl_modexp.sv
module rl_modexp #(
  parameter int W = 224
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] exp_i,
  input  logic [W-1:0] mod_i,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] res_o
);
  import rlx_pkg::*;

  logic [RLX_LANES-1:0][W-1:0] mul_a, mul_b, lane_prod;
  logic [RLX_LANES-1:0]        lane_done;
  logic [W-1:0]                mod_sel, n_q;
  logic                        from_in, bit_next, mul_load;

  rlx_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .x_in(base_i), .e_in(exp_i), .n_in(mod_i),
    .out_ready(out_ready),
    .done_acc(lane_done[RLX_ACC]), .done_sq(lane_done[RLX_SQ]),
    .prod_acc(lane_prod[RLX_ACC]), .prod_sq(lane_prod[RLX_SQ]),
    .in_ready(in_ready), .out_valid(out_valid), .result(res_o),
    .from_in(from_in), .bit_next(bit_next), .mul_load(mul_load), .n_q(n_q)
  );

  rlx_opsel #(.W(W)) u_opsel (
    .from_in(from_in), .bit_in(exp_i[0]), .bit_next(bit_next),
    .x_in(base_i), .n_in(mod_i), .n_q(n_q),
    .prod_acc(lane_prod[RLX_ACC]), .prod_sq(lane_prod[RLX_SQ]),
    .mul_a(mul_a), .mul_b(mul_b), .mod_o(mod_sel)
  );

  for (genvar g = 0; g < RLX_LANES; g++) begin : g_lane
    rlx_modmul #(.W(W)) u_mul (
      .clk(clk), .rst_n(rst_n), .load(mul_load),
      .a_i(mul_a[g]), .b_i(mul_b[g]), .n_i(mod_sel),
      .prod_o(lane_prod[g]), .done_o(lane_done[g])
    );
  end
endmodule

// File: rtl/rl_modexp_chk.sv
module rl_modexp_chk #(
  parameter int W = 224
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] exp_in,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] result,
  input logic         done_acc,
  input logic         done_sq
);
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R2
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R4
  zero_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && exp_in == '0) |=> (out_valid && result == W'(1)));

  // R5
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(in_valid && in_ready) || $past(done_acc)));

  // R7
  lanes_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc == done_sq);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result)));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));
endmodule

bind rl_modexp rl_modexp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .exp_in(exp_i), .out_valid(out_valid), .out_ready(out_ready), .result(res_o),
  .done_acc(lane_done[0]), .done_sq(lane_done[1])
);

// File: tb/test_rl_modexp.sv
`timescale 1ns/1ps
module test_rl_modexp;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, out_ready = 1'b0;
  logic         in_ready, out_valid;
  logic [W-1:0] base_i = '0, exp_i = '0, mod_i = '0, res_o;

  always #2.5 clk = ~clk;

  rl_modexp #(.W(W)) i_rl_modexp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .base_i(base_i), .exp_i(exp_i), .mod_i(mod_i),
    .out_valid(out_valid), .out_ready(out_ready), .res_o(res_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [W-1:0] res;
    int           lat;
    int           t0;
    int           hold;
    string        rtag;
    string        ltag;
  } item_t;

  item_t sb[$];
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic longint mexp(longint x, longint e, longint n);
    longint a = 1, s = x;
    while (e != 0) begin
      if (e[0]) a = (a * s) % n;
      s = (s * s) % n;
      e = e >> 1;
    end
    return a;
  endfunction

  function automatic int blen(longint e);
    int l = 0;
    while (e != 0) begin l++; e = e >> 1; end
    return l;
  endfunction

  task automatic send(input logic [W-1:0] x, input logic [W-1:0] e,
                      input logic [W-1:0] n, input int hold, input bit junk,
                      input string rtag, input string ltag);
    item_t it;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    base_i = x; exp_i = e; mod_i = n; in_valid = 1'b1;
    it.res  = W'(mexp(longint'(x), longint'(e), longint'(n)));
    it.lat  = blen(longint'(e)) * W;
    it.t0   = cyc + 1;
    it.hold = hold;
    it.rtag = rtag;
    it.ltag = ltag;
    sb.push_back(it);
    @(negedge clk);
    if (junk) begin
      for (int k = 0; k < 3; k++) begin
        base_i = ~x; exp_i = 16'h0003; mod_i = 16'h0007;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2", "unexpected result", longint'(res_o), 0);
        end else begin
          it = sb.pop_front();
          chk(res_o == it.res, it.rtag, "result", longint'(res_o), longint'(it.res));
          chk(cyc - it.t0 == it.lat, it.ltag, "latency", cyc - it.t0, it.lat);
          chk(!in_ready, "R2", "in_ready while result pending", longint'(in_ready), 0);
          for (int k = 0; k < it.hold; k++) begin
            @(negedge clk);
            chk(out_valid && res_o == it.res, "R8", "held result",
                longint'(res_o), longint'(it.res));
          end
          out_ready = 1'b1;
          @(negedge clk);
          out_ready = 1'b0;
          chk(!out_valid && in_ready, "R9", "release (valid,ready)",
              longint'({out_valid, in_ready}), 1);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R5 watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid, "R1", "in reset (ready,valid)",
        longint'({in_ready, out_valid}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R1", "after reset (ready,valid)",
        longint'({in_ready, out_valid}), 2);

    send(16'd3,     16'd0,      16'd7,     0, 1'b0, "R4", "R4");
    send(16'd5,     16'd1,      16'd13,    0, 1'b0, "R3", "R5");
    send(16'd2,     16'd10,     16'd1000,  2, 1'b0, "R3", "R5");
    send(16'd1234,  16'hFFFF,   16'd65521, 3, 1'b0, "R3", "R6");
    send(16'd1234,  16'h8000,   16'd65521, 0, 1'b0, "R3", "R7");
    send(16'd0,     16'd7,      16'd11,    0, 1'b0, "R3", "R5");
    send(16'd1,     16'd5,      16'd2,     1, 1'b0, "R3", "R5");
    send(16'd40000, 16'hBEEF,   16'd40961, 0, 1'b1, "R2", "R6");
    send(16'd777,   16'h00F0,   16'd12345, 4, 1'b0, "R3", "R5");
    send(16'd9,     16'h0081,   16'd12345, 0, 1'b0, "R3", "R7");
    send(16'd500,   16'd0,      16'd999,   2, 1'b0, "R4", "R4");

    @(negedge clk);
    while (sb.size() != 0 || out_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule